// File: doc/BRIEF.md
# Per-CPU Priority Level Combiner

This block serves one CPU. It keeps that CPU's own pending word, which holds fifteen software interrupt requests, a timer request and a level-15 request. It merges that word with the hardware priority levels that a system router has already selected for this CPU. The result is a registered vector of level-sensitive priority lines for levels 1 to 15. Line 0 exists only to keep the indexing natural, and it is always low.

A 32-bit word-addressed register port gives software three operations: read the pending word, clear chosen bits, and set software requests. Software requests sit in the upper half-word and map onto priority levels after a 16-bit right shift. The timer and level-15 requests bypass every mask except one global disable flag. The hardware level bits seen in the readable word come from a display vector that the router supplies. They are not stored here.

Top module: `pcl_cpu_combiner`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the level outputs are all low and the pending word reads zero, provided the timer and broadcast inputs are low.
- R2: Address 0 on the 2-bit word address reads the pending word. Addresses 1, 2 and 3 read zero.
- R3: A write to address 2 ORs write data bits 31..17 into the software requests (mask 0xFFFE0000). Other data bits are ignored.
- R4: A write to address 1 clears the pending bits that are set in the data under mask 0xFFFE8000, which covers the software requests and bit 15. The timer bit (bit 14) and the display bits cannot be cleared this way. A write to address 3 changes nothing.
- R5: Pending bit 14 copies the timer input as sampled at the last clock edge.
- R6: Pending bit 15 is set when a rising edge of the level-15 broadcast is sampled and is cleared when a falling edge is sampled. If a broadcast edge and a clear write arrive together, the edge wins.
- R7: Software request bit 16+k drives level k (k = 1..15), whatever the global disable flag says.
- R8: Pending bits 14 and 15 drive levels 14 and 15 only while the global disable input is low.
- R9: Each routed hardware level k (k = 1..15) is ORed into output level k. Output level 0 is always low.
- R10: Pending bits 13..1 show display vector bits 13..1 directly, with no register on the path.
- R11: The level outputs are registered. A register write or an input change shows on the outputs at the first clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Word address: 0 read, 1 clear, 2 set, 3 reserved |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| routed_lvl | input | 15 | Hardware levels 15..1 already routed and gated for this CPU |
| disp_lvl | input | 13 | Router display levels 13..1 for the readable word |
| glob_dis | input | 1 | Global disable: masks the timer and level-15 paths |
| lvl15_bcast | input | 1 | Level-15 broadcast request |
| timer_in | input | 1 | Per-CPU timer request |
| irl_o | output | 16 | Priority level lines, bit k is level k |

## Verification
On every cycle, the assertions check these rules: software requests always reach their levels, the global disable blocks the timer and level-15 paths, routed levels pass through, set and clear writes take effect, and broadcast edges set and clear bit 15. Only the bench scenarios can show the behaviours below. Reserved addresses read zero. The timer bit survives a clear write. Each output moves exactly one edge after its cause and not earlier. The display vector reaches the read port unregistered.

// File: rtl/pcl_pkg.sv
// Package: shared widths, bit positions and address codes for the
// per-CPU priority level combiner. Assumes 16 priority levels and a
// pending word twice that wide.
package pcl_pkg;
    localparam int unsigned LVL_N  = 16;
    localparam int unsigned WORD_W = 2 * LVL_N;

    typedef enum logic [1:0] {
        OFF_READ = 2'd0,
        OFF_CLR  = 2'd1,
        OFF_SET  = 2'd2,
        OFF_RSVD = 2'd3
    } reg_off_e;
endpackage

// File: rtl/pcl_pend_store.sv
// Locally held part of the pending word: software requests, the
// level-15 bit and the timer bit. Also gives the next-state values, so
// that the output stage can register them in the same edge.
// Assumes set_en and clr_en are never high together.
module pcl_pend_store #(
    parameter int unsigned LVL_N = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [LVL_N-1:1] soft_data,
    input  logic             l15_clr_bit,
    input  logic             timer_i,
    input  logic             bcast_i,
    output logic [LVL_N-1:1] soft_q,
    output logic             l15_q,
    output logic             tmr_q,
    output logic [LVL_N-1:1] soft_nxt,
    output logic             l15_nxt,
    output logic             tmr_nxt
);
    logic bcast_q;

    // Next software requests: OR on a set write, AND-NOT on a clear write.
    always_comb begin
        soft_nxt = soft_q;
        if (set_en)      soft_nxt = soft_q | soft_data;
        else if (clr_en) soft_nxt = soft_q & ~soft_data;
    end

    // Next level-15 bit: broadcast edges take priority over a clear write.
    always_comb begin
        l15_nxt = l15_q;
        if (bcast_i && !bcast_q)      l15_nxt = 1'b1;
        else if (!bcast_i && bcast_q) l15_nxt = 1'b0;
        else if (clr_en && l15_clr_bit) l15_nxt = 1'b0;
    end

    // The timer bit copies the timer input.
    always_comb tmr_nxt = timer_i;

    // Register the local pending state and the broadcast history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q  <= '0;
            l15_q   <= 1'b0;
            tmr_q   <= 1'b0;
            bcast_q <= 1'b0;
        end else begin
            soft_q  <= soft_nxt;
            l15_q   <= l15_nxt;
            tmr_q   <= tmr_nxt;
            bcast_q <= bcast_i;
        end
    end

    p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(set_en) |-> ((soft_q & $past(soft_data)) == $past(soft_data)));

    p_clear_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(clr_en) |-> ((soft_q & $past(soft_data)) == '0));

    p_bcast_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(bcast_i) && !$past(bcast_q) |-> l15_q);

    p_bcast_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(bcast_i) && $past(bcast_q) |-> !l15_q);
endmodule

// File: rtl/pcl_lvl_merge.sv
// Output stage: merges the next-state pending bits with the routed
// hardware levels into registered level lines. Level 0 is always low.
// Assumes the timer sits at level LVL_N-2 and the broadcast at LVL_N-1.
module pcl_lvl_merge #(
    parameter int unsigned LVL_N = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_N-1:1] soft_nxt,
    input  logic             l15_nxt,
    input  logic             tmr_nxt,
    input  logic [LVL_N-1:1] routed_i,
    input  logic             gdis_i,
    output logic [LVL_N-1:0] lvl_o
);
    localparam int unsigned TOP_LVL = LVL_N - 1;
    localparam int unsigned TMR_LVL = LVL_N - 2;

    logic [LVL_N-1:1] lvl_d;
    logic [LVL_N-1:1] lvl_q;

    // Per-level merge; the two top levels add their gated local requests.
    for (genvar k = 1; k < LVL_N; k++) begin : g_lvl
        if (k == TOP_LVL) begin : g_top
            assign lvl_d[k] = soft_nxt[k] | routed_i[k] | (l15_nxt & ~gdis_i);
        end else if (k == TMR_LVL) begin : g_tmr
            assign lvl_d[k] = soft_nxt[k] | routed_i[k] | (tmr_nxt & ~gdis_i);
        end else begin : g_plain
            assign lvl_d[k] = soft_nxt[k] | routed_i[k];
        end
    end

    // Register the level lines.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    assign lvl_o = {lvl_q, 1'b0};

    p_soft_unmasked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((lvl_o[LVL_N-1:1] & $past(soft_nxt)) == $past(soft_nxt)));

    p_routed_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((lvl_o[LVL_N-1:1] & $past(routed_i)) == $past(routed_i)));

    p_gdis_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(gdis_i) |->
        (lvl_o[LVL_N-1:LVL_N-2] == ($past(soft_nxt[LVL_N-1:LVL_N-2]) | $past(routed_i[LVL_N-1:LVL_N-2]))));
endmodule

// File: rtl/pcl_cpu_combiner.sv
// Top: per-CPU priority level combiner. It decodes the register port,
// holds the local pending state, builds the read word from the local
// bits and the router's display vector, and drives registered level lines.
// Assumes a single-cycle write strobe and combinational reads.
module pcl_cpu_combiner
    import pcl_pkg::*;
#(
    parameter int unsigned NLVL = pcl_pkg::LVL_N
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          bus_addr,
    input  logic                bus_wr,
    input  logic [2*NLVL-1:0]   bus_wdata,
    output logic [2*NLVL-1:0]   bus_rdata,
    input  logic [NLVL-1:1]     routed_lvl,
    input  logic [NLVL-3:1]     disp_lvl,
    input  logic                glob_dis,
    input  logic                lvl15_bcast,
    input  logic                timer_in,
    output logic [NLVL-1:0]     irl_o
);
    localparam int unsigned W = 2 * NLVL;

    logic            set_en, clr_en;
    logic [NLVL-1:1] soft_q, soft_nxt;
    logic            l15_q, tmr_q, l15_nxt, tmr_nxt;
    logic [W-1:0]    pend_word;

    // Decode the write strobes from the word address.
    always_comb begin
        set_en = bus_wr && (reg_off_e'(bus_addr) == OFF_SET);
        clr_en = bus_wr && (reg_off_e'(bus_addr) == OFF_CLR);
    end

    pcl_pend_store #(.LVL_N(NLVL)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_en      (set_en),
        .clr_en      (clr_en),
        .soft_data   (bus_wdata[W-1:NLVL+1]),
        .l15_clr_bit (bus_wdata[NLVL-1]),
        .timer_i     (timer_in),
        .bcast_i     (lvl15_bcast),
        .soft_q      (soft_q),
        .l15_q       (l15_q),
        .tmr_q       (tmr_q),
        .soft_nxt    (soft_nxt),
        .l15_nxt     (l15_nxt),
        .tmr_nxt     (tmr_nxt)
    );

    pcl_lvl_merge #(.LVL_N(NLVL)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_nxt (soft_nxt),
        .l15_nxt  (l15_nxt),
        .tmr_nxt  (tmr_nxt),
        .routed_i (routed_lvl),
        .gdis_i   (glob_dis),
        .lvl_o    (irl_o)
    );

    // Assemble the readable pending word; bits 0 and NLVL read zero.
    assign pend_word = {soft_q, 1'b0, l15_q, tmr_q, disp_lvl, 1'b0};

    // Only address 0 returns data.
    always_comb begin
        bus_rdata = '0;
        if (reg_off_e'(bus_addr) == OFF_READ) bus_rdata = pend_word;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (irl_o == '0) && (soft_q == '0));
endmodule

// File: tb/pcl_cpu_combiner_bench.sv
module pcl_cpu_combiner_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:1] routed_lvl = '0;
    logic [13:1] disp_lvl = '0;
    logic        glob_dis = 1'b0;
    logic        lvl15_bcast = 1'b0;
    logic        timer_in = 1'b0;
    logic [15:0] irl_o;

    int n_chk = 0;
    int n_fail = 0;

    // Bench model of the local pending state.
    logic [15:1] m_soft = '0;
    logic        m_l15 = 1'b0;
    logic        m_tmr = 1'b0;

    always #10 clk = ~clk;

    pcl_cpu_combiner u_pcl_cpu_combiner (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .routed_lvl(routed_lvl),
        .disp_lvl(disp_lvl), .glob_dis(glob_dis), .lvl15_bcast(lvl15_bcast),
        .timer_in(timer_in), .irl_o(irl_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_out();
        logic [15:0] v;
        v = {m_soft, 1'b0} | {routed_lvl, 1'b0};
        if (!glob_dis) v = v | {m_l15, m_tmr, 14'b0};
        return v;
    endfunction

    function automatic logic [31:0] exp_word();
        return {m_soft, 1'b0, m_l15, m_tmr, disp_lvl, 1'b0};
    endfunction

    task automatic read_at(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #2;
        bus_wr = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 out in reset", {16'b0, irl_o}, 32'h0);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check("R1 out after reset", {16'b0, irl_o}, 32'h0);
        read_at(2'd0, d);
        check("R1 pending after reset", d, 32'h0);
    endtask

    task automatic t_set();
        logic [31:0] d;
        bus_write(2'd2, 32'h0002_FFFF);
        m_soft = m_soft | 15'h0001;
        read_at(2'd0, d);
        check("R3 set low bits masked", d, exp_word());
        check("R7 soft bit17 to level1", {16'b0, irl_o}, {16'b0, exp_out()});
        bus_write(2'd2, 32'hFFFF_FFFF);
        m_soft = '1;
        read_at(2'd0, d);
        check("R3 set all soft", d, 32'hFFFE_0000);
        check("R7 all soft levels, R9 level0 low", {16'b0, irl_o}, 32'h0000_FFFE);
    endtask

    task automatic t_offsets();
        logic [31:0] d;
        read_at(2'd1, d); check("R2 addr1 reads zero", d, 32'h0);
        read_at(2'd2, d); check("R2 addr2 reads zero", d, 32'h0);
        read_at(2'd3, d); check("R2 addr3 reads zero", d, 32'h0);
        bus_write(2'd3, 32'h0000_0000);
        read_at(2'd0, d); check("R4 addr3 write ignored", d, exp_word());
    endtask

    task automatic t_timer();
        logic [31:0] d;
        @(negedge clk);
        timer_in = 1'b1;
        #1;
        check("R11 no change before edge", {16'b0, irl_o}, {16'b0, exp_out()});
        @(posedge clk); #2;
        m_tmr = 1'b1;
        check("R5 R11 timer level after edge", {16'b0, irl_o}, {16'b0, exp_out()});
        read_at(2'd0, d);
        check("R5 timer pending bit14", d, exp_word());
    endtask

    task automatic t_clear();
        logic [31:0] d;
        bus_write(2'd1, 32'hFFFF_FFFF);
        m_soft = '0; m_l15 = 1'b0;
        read_at(2'd0, d);
        check("R4 clear keeps timer", d, 32'h0000_4000);
        check("R4 clear outputs", {16'b0, irl_o}, {16'b0, exp_out()});
        @(negedge clk); timer_in = 1'b0;
        @(posedge clk); #2; m_tmr = 1'b0;
        check("R5 timer falls", {16'b0, irl_o}, 32'h0);
    endtask

    task automatic t_l15();
        logic [31:0] d;
        @(negedge clk); lvl15_bcast = 1'b1;
        @(posedge clk); #2; m_l15 = 1'b1;
        read_at(2'd0, d);
        check("R6 rise sets bit15", d, exp_word());
        check("R6 level15 out", {16'b0, irl_o}, 32'h0000_8000);
        bus_write(2'd1, 32'h0000_8000);
        m_l15 = 1'b0;
        read_at(2'd0, d);
        check("R4 clear bit15", d, exp_word());
        @(negedge clk); lvl15_bcast = 1'b0;
        bus_write(2'd2, 32'h0000_0000);
        read_at(2'd0, d);
        check("R6 fall keeps clear", d, exp_word());
        @(negedge clk); lvl15_bcast = 1'b1;
        @(posedge clk); #2; m_l15 = 1'b1;
        @(negedge clk); lvl15_bcast = 1'b0;
        @(posedge clk); #2; m_l15 = 1'b0;
        read_at(2'd0, d);
        check("R6 fall clears bit15", d, 32'h0);
    endtask

    task automatic t_gdis();
        logic [31:0] d;
        @(negedge clk);
        glob_dis = 1'b1; timer_in = 1'b1; lvl15_bcast = 1'b1;
        @(posedge clk); #2; m_tmr = 1'b1; m_l15 = 1'b1;
        check("R8 disable masks 14 and 15", {16'b0, irl_o}, 32'h0);
        bus_write(2'd2, 32'h8008_0000);
        m_soft[15] = 1'b1; m_soft[3] = 1'b1;
        check("R7 soft passes disable", {16'b0, irl_o}, 32'h0000_8008);
        @(negedge clk); glob_dis = 1'b0;
        @(posedge clk); #2;
        check("R8 enable lets 14 and 15", {16'b0, irl_o}, 32'h0000_C008);
        read_at(2'd0, d);
        check("R8 pending view", d, exp_word());
        bus_write(2'd1, 32'hFFFF_FFFF);
        m_soft = '0; m_l15 = 1'b0;
        @(negedge clk); timer_in = 1'b0; lvl15_bcast = 1'b0;
        @(posedge clk); #2; m_tmr = 1'b0;
        check("R4 R6 cleanup", {16'b0, irl_o}, 32'h0);
    endtask

    task automatic t_route();
        logic [31:0] d;
        @(negedge clk);
        routed_lvl = 15'h0052; glob_dis = 1'b1;
        @(posedge clk); #2;
        check("R9 routed levels", {16'b0, irl_o}, {16'b0, exp_out()});
        disp_lvl = 13'h1ABC;
        read_at(2'd0, d);
        check("R10 display bits shown", d, exp_word());
        @(negedge clk); routed_lvl = '0; glob_dis = 1'b0;
        @(posedge clk); #2;
        check("R9 routed removed", {16'b0, irl_o}, 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_set();
        t_offsets();
        t_timer();
        t_clear();
        t_l15();
        t_gdis();
        t_route();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule